// File: doc/BRIEF.md
# Calendar Real-Time Clock

This peripheral keeps wall-clock time as a packed binary calendar: second, minute, hour, day of month, month, year within the century and century. A prescaler divides the system clock down to one increment per second. Carries ripple from seconds up to the century, and day-of-month rollover follows the length of each month, including leap-year February.

Software reaches the block through a plain 32-bit register port made of a byte address, a write strobe, write data and registered read data. A control word holds a run bit and a write-permit bit. Time words can be loaded only while the permit bit is set. While the run bit is clear, the stored time stays frozen and reads return it unchanged. The alarm words are decoded, but they read as zero and ignore writes.

Top module: `cal_rtc`

## Requirements
- R1: After reset, every readable word (time word A at 0x00, time word B at 0x04, control at 0x10) reads zero, so the clock is stopped and write-protected.
- R2: The control word at 0x10 accepts every write and reads back the full 32-bit value last written; bit 0 is run, bit 1 is write-permit.
- R3: A write to 0x00 or 0x04 while control bit 1 is clear leaves the stored time unchanged.
- R4: Time word A packs day [28:24], hour [20:16], minute [13:8] and second [5:0]; all other bits read zero.
- R5: Time word B packs century [20:16], year within century [14:8] and month [3:0] (1 to 12); all other bits read zero.
- R6: While control bit 0 is clear, the time does not advance and reads return the stored value.
- R7: While control bit 0 is set, the time advances by one second every TICK_DIV clock cycles. An accepted time write clears the prescaler, so the first increment after it lands TICK_DIV cycles later, and a tick in the same cycle as that write is dropped.
- R8: Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day.
- R9: Day of month wraps to 1 after the last day of the month: 30 for April, June, September and November, 31 for the others, and 28 for February, or 29 in a leap year. A leap year is one whose year-in-century is a non-zero multiple of 4, or year 0 of a century that is a multiple of 4.
- R10: Month wraps 12 to 1 into the year, year wraps 99 to 0 into the century, and the century wraps 31 to 0.
- R11: Reads of 0x08, 0x14 and any undecoded word return zero, and writes to them change neither control nor time.
- R12: Read data is registered: rdata_o shows the word addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address; the word index is addr_i >> 2 |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the previous cycle's address |

## Verification
Read data appears one clock edge after the address is presented, so every read is driven at a falling edge and sampled at the next falling edge. A write takes effect at the rising edge inside its strobe. An enable written at edge E produces its first increment at edge E+TICK_DIV. The table walk therefore holds the run bit for exactly TICK_DIV edges and then clears it, which yields exactly one increment, and reads the frozen result afterwards. The prescaler-clear check holds the address on time word A and samples at the edge TICK_DIV cycles after the load, then one edge later, to confirm that the increment arrives in that cycle and not earlier.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  typedef struct packed {
    logic [4:0] cent;
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  localparam int unsigned WORD_TA    = 0;
  localparam int unsigned WORD_TB    = 1;
  localparam int unsigned WORD_ALM   = 2;
  localparam int unsigned WORD_CTRL  = 4;
  localparam int unsigned WORD_ALMST = 5;

  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_PERMIT = 1;

  function automatic logic [31:0] pack_ta(cal_t c);
    return {3'b0, c.day, 3'b0, c.hour, 2'b0, c.min, 2'b0, c.sec};
  endfunction

  function automatic logic [31:0] pack_tb(cal_t c);
    return {11'b0, c.cent, 1'b0, c.year, 4'b0, c.mon};
  endfunction

  // full year divisible by 400 <=> century divisible by 4 when year-in-century is 0
  function automatic logic is_leap(logic [4:0] cent, logic [6:0] year);
    if (year != 7'd0) return (year[1:0] == 2'b00);
    return (cent[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_len(logic [3:0] mon, logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  // a load in the same cycle swallows the tick
  assign tick_o  = en_i && at_last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_time.sv
module cal_rtc_time
  import cal_rtc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ld_ta_i,
  input  logic ld_tb_i,
  input  cal_t ld_val_i,
  output cal_t cal_o
);
  cal_t cal_q, cal_d;
  logic w_sec, w_min, w_hour, w_day, w_mon, w_year;
  logic [4:0] last_day;

  always_comb begin
    last_day = month_len(cal_q.mon, is_leap(cal_q.cent, cal_q.year));
    w_sec    = cal_q.sec  >= 6'd59;
    w_min    = cal_q.min  >= 6'd59;
    w_hour   = cal_q.hour >= 5'd23;
    w_day    = cal_q.day  >= last_day;
    w_mon    = cal_q.mon  >= 4'd12;
    w_year   = cal_q.year >= 7'd99;

    cal_d = cal_q;
    if (tick_i) begin
      cal_d.sec = w_sec ? 6'd0 : cal_q.sec + 6'd1;
      if (w_sec) begin
        cal_d.min = w_min ? 6'd0 : cal_q.min + 6'd1;
        if (w_min) begin
          cal_d.hour = w_hour ? 5'd0 : cal_q.hour + 5'd1;
          if (w_hour) begin
            cal_d.day = w_day ? 5'd1 : cal_q.day + 5'd1;
            if (w_day) begin
              cal_d.mon = w_mon ? 4'd1 : cal_q.mon + 4'd1;
              if (w_mon) begin
                cal_d.year = w_year ? 7'd0 : cal_q.year + 7'd1;
                if (w_year) cal_d.cent = cal_q.cent + 5'd1;
              end
            end
          end
        end
      end
    end
    if (ld_ta_i) begin
      cal_d.day  = ld_val_i.day;
      cal_d.hour = ld_val_i.hour;
      cal_d.min  = ld_val_i.min;
      cal_d.sec  = ld_val_i.sec;
    end
    if (ld_tb_i) begin
      cal_d.cent = ld_val_i.cent;
      cal_d.year = ld_val_i.year;
      cal_d.mon  = ld_val_i.mon;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= '0;
    else         cal_q <= cal_d;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word;
  logic [31:0]      ctrl_q;
  logic [31:0]      rdata_d;
  logic             ld_ta, ld_tb, tick;
  cal_t             cal_q, ld_val;
  logic             unused_addr;

  assign word        = addr_i[ADDR_W-1:2];
  assign unused_addr = ^addr_i[1:0];

  assign ld_ta = we_i && ctrl_q[BIT_PERMIT] && (word == IDX_W'(WORD_TA));
  assign ld_tb = we_i && ctrl_q[BIT_PERMIT] && (word == IDX_W'(WORD_TB));

  assign ld_val = '{cent: wdata_i[20:16], year: wdata_i[14:8], mon: wdata_i[3:0],
                    day:  wdata_i[28:24], hour: wdata_i[20:16],
                    min:  wdata_i[13:8],  sec:  wdata_i[5:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ctrl_q <= '0;
    else if (we_i && word == IDX_W'(WORD_CTRL))   ctrl_q <= wdata_i;
  end

  cal_rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q[BIT_RUN]),
    .clr_i  (ld_ta || ld_tb),
    .tick_o (tick)
  );

  cal_rtc_time u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ld_ta_i  (ld_ta),
    .ld_tb_i  (ld_tb),
    .ld_val_i (ld_val),
    .cal_o    (cal_q)
  );

  always_comb begin
    rdata_d = '0;
    if (word == IDX_W'(WORD_TA))        rdata_d = pack_ta(cal_q);
    else if (word == IDX_W'(WORD_TB))   rdata_d = pack_tb(cal_q);
    else if (word == IDX_W'(WORD_CTRL)) rdata_d = ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-3:0] word_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [31:0]       ctrl_q,
  input logic              tick,
  input cal_t              cal_q
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && word_i == IDX_W'(WORD_CTRL)) |=> (ctrl_q == $past(wdata_i)));

  // R3
  locked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ctrl_q[BIT_PERMIT] && !ctrl_q[BIT_RUN]) |=> $stable(cal_q));

  // R6
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[BIT_RUN] && !we_i) |=> $stable(cal_q));

  // R8
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cal_q.sec == 6'd59) |=> (cal_q.sec == 6'd0));

  // R4
  ta_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i == IDX_W'(WORD_TA)) |=>
      (rdata_o[31:29] == 3'd0 && rdata_o[23:21] == 3'd0 &&
       rdata_o[15:14] == 2'd0 && rdata_o[7:6] == 2'd0));

  // R11
  alarm_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i == IDX_W'(WORD_ALM) || word_i == IDX_W'(WORD_ALMST)) |=> (rdata_o == 32'd0));
endmodule

bind cal_rtc cal_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .word_i  (word),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ctrl_q  (ctrl_q),
  .tick    (tick),
  .cal_q   (cal_q)
);

// File: tb/tb_cal_rtc.sv
module tb_cal_rtc;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int NV    = 14;

  localparam logic [4:0] A_TA = 5'h00, A_TB = 5'h04, A_ALM = 5'h08,
                         A_GAP = 5'h0C, A_CTRL = 5'h10, A_ALMST = 5'h14, A_UND = 5'h18;

  // {ta_in, tb_in, ta_exp, tb_exp}: each row advances by exactly one second
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'h010A1E05, 32'h00141803, 32'h010A1E06, 32'h00141803}, // R7 plain
    '{32'h0F08103B, 32'h00141803, 32'h0F081100, 32'h00141803}, // R8 sec
    '{32'h0F083B3B, 32'h00141803, 32'h0F090000, 32'h00141803}, // R8 min
    '{32'h0F173B3B, 32'h00141803, 32'h10000000, 32'h00141803}, // R8 hour
    '{32'h1E173B3B, 32'h00141804, 32'h01000000, 32'h00141805}, // R9 30-day
    '{32'h1C173B3B, 32'h00141802, 32'h1D000000, 32'h00141802}, // R9 leap 28->29
    '{32'h1D173B3B, 32'h00141802, 32'h01000000, 32'h00141803}, // R9 leap 29->1
    '{32'h1C173B3B, 32'h00141702, 32'h01000000, 32'h00141703}, // R9 common
    '{32'h1C173B3B, 32'h00130002, 32'h01000000, 32'h00130003}, // R9 century common
    '{32'h1C173B3B, 32'h00140002, 32'h1D000000, 32'h00140002}, // R9 century leap
    '{32'h1F173B3B, 32'h00141801, 32'h01000000, 32'h00141802}, // R9 31-day
    '{32'h1F173B3B, 32'h0014170C, 32'h01000000, 32'h00141801}, // R10 year
    '{32'h1F173B3B, 32'h0014630C, 32'h01000000, 32'h00150001}, // R10 century
    '{32'h1F173B3B, 32'h001F630C, 32'h01000000, 32'h00000001}  // R10 century wrap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] got;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cal_rtc #(.TICK_DIV(DIV), .ADDR_W(5)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_TA, got);   check("R1 time A", got, 32'h0);
    rd(A_TB, got);   check("R1 time B", got, 32'h0);
    rd(A_CTRL, got); check("R1 control", got, 32'h0);

    wr(A_TA, 32'h01020304);
    rd(A_TA, got);   check("R3 locked A", got, 32'h0);
    wr(A_TB, 32'h00141803);
    rd(A_TB, got);   check("R3 locked B", got, 32'h0);

    wr(A_CTRL, 32'hA5A55A5A);
    rd(A_CTRL, got); check("R2 readback", got, 32'hA5A55A5A);

    wr(A_TA, 32'hFFFFFFFF);
    rd(A_TA, got);   check("R4 field mask", got, 32'h1F1F3F3F);
    wr(A_TB, 32'hFFFFFFFF);
    rd(A_TB, got);   check("R5 field mask", got, 32'h001F7F0F);

    repeat (3 * DIV) @(negedge clk);
    rd(A_TA, got);   check("R6 frozen", got, 32'h1F1F3F3F);

    wr(A_ALM, 32'hFFFFFFFF);
    wr(A_ALMST, 32'h12345678);
    wr(A_GAP, 32'h0);
    rd(A_ALM, got);   check("R11 alarm read", got, 32'h0);
    rd(A_ALMST, got); check("R11 status read", got, 32'h0);
    rd(A_GAP, got);   check("R11 gap read", got, 32'h0);
    rd(A_UND, got);   check("R11 undecoded read", got, 32'h0);
    rd(A_CTRL, got);  check("R11 control kept", got, 32'hA5A55A5A);
    rd(A_TA, got);    check("R11 time kept", got, 32'h1F1F3F3F);

    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 32'h2);
      wr(A_TA, VEC[i][0]);
      wr(A_TB, VEC[i][1]);
      wr(A_CTRL, 32'h3);
      repeat (DIV - 1) @(negedge clk);
      wr(A_CTRL, 32'h2);
      rd(A_TA, got); check($sformatf("R8/R9/R10 row %0d time A", i), got, VEC[i][2]);
      rd(A_TB, got); check($sformatf("R5/R10 row %0d time B", i), got, VEC[i][3]);
    end

    // R7: load while running clears the prescaler
    wr(A_CTRL, 32'h3);
    repeat (DIV + 2) @(negedge clk);
    wr(A_TA, 32'h05060708);
    repeat (DIV) @(negedge clk);
    check("R7 no early tick", rdata, 32'h05060708);
    @(negedge clk);
    check("R7 tick after full period", rdata, 32'h05060709);

    // R12: one-cycle read latency
    addr = A_CTRL;
    #1;
    check("R12 old data held", rdata, 32'h05060709);
    @(negedge clk);
    check("R12 new data after one edge", rdata, 32'h3);

    wr(A_CTRL, 32'h0);
    finish_run();
  end
endmodule